// File: doc/BRIEF.md
# Operand Address Generator for an 8-bit Processor Core

This block turns an addressing mode, two operand bytes and the X and Y index registers into the 16-bit address of a memory operand. Direct modes (page zero, page zero indexed, absolute and absolute indexed) are pure arithmetic and finish one cycle after the request. Modes that go through a pointer held in page zero fetch the two pointer bytes, low byte first, over a byte-wide read port with one cycle of read latency. Those modes then apply any Y offset and report the result.

A request is a one-cycle `start` pulse with the mode and operands valid in that cycle. The block answers with a one-cycle `done` pulse. `ea` and `err` are then held until the next completion. Modes that only steer the program counter, and unused mode codes, complete at once with `err` set. The data access itself is left to the caller.

Top module: `opaddr_gen`

## Requirements
- R1: Mode 0 (page zero) and mode 9 (page zero with relative target) give `ea = {8'h00, op1}`. `done` is high in the first cycle after the edge that accepts `start`.
- R2: Mode 1 (page zero plus X) gives `ea = {8'h00, (op1 + X) mod 256}`.
- R3: Mode 2 (page zero plus Y) gives `ea = {8'h00, (op1 + Y) mod 256}`.
- R4: Mode 3 (page zero indirect) reads pointer bytes at `op1` and `(op1 + 1) mod 256`, both in page zero. `ea` is `{high byte, low byte}`.
- R5: Mode 4 (X-indexed indirect) reads pointer bytes at `(op1 + X) mod 256` and `(op1 + X + 1) mod 256`, both in page zero. `ea` is the pointer.
- R6: Mode 5 (indirect, then Y-indexed) reads the pointer at `op1` and `(op1 + 1) mod 256`. `ea = (pointer + Y) mod 65536`.
- R7: Mode 6 (absolute) gives `ea = 256*op2 + op1`. Modes 7 and 8 add X or Y, respectively, modulo 65536.
- R8: Modes 10, 11 and 12 (jump-only and branch modes) and codes 13 to 15 complete in the first cycle after acceptance. They set `done` with `err = 1` and `ea = 0`, and issue no read.
- R9: Pointer modes (3, 4, 5) issue exactly two reads on consecutive cycles, low byte first. `done` is high in the fourth cycle after the accepting edge, and never in a cycle in which `rd_en` is high.
- R10: `done` is high for a single cycle per request. `ea` and `err` change only in a cycle with `done` high and hold otherwise. `err` is 0 for every data mode.
- R11: `start` is ignored while a pointer fetch is in progress. It causes no extra completion and does not alter the result.
- R12: During and after reset `done`, `err`, `rd_en` and `ea` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse; mode and operands valid with it |
| mode | input | 4 | Addressing mode code (see R1 to R8) |
| op1 | input | 8 | First operand byte (low byte / page-zero address) |
| op2 | input | 8 | Second operand byte (high byte) |
| idx_x | input | 8 | X index register |
| idx_y | input | 8 | Y index register |
| rd_en | output | 1 | Pointer read request |
| rd_addr | output | 16 | Pointer read address |
| rd_data | input | 8 | Read data, valid the cycle after `rd_en` |
| ea | output | 16 | Computed operand address |
| done | output | 1 | Completion pulse |
| err | output | 1 | Mode yields no data address |

## Verification
The in-line assertions watch, on every cycle, the shape of the pointer fetch: two back-to-back reads that start in page zero and step the low address byte by one. They also check that `done` never coincides with a read, that `ea` and `err` stay stable between completions, and that an error result carries a zero address. Only the directed scenarios can show the address arithmetic itself. That covers wrap inside page zero against carry into the high byte, the Y offset applied after the pointer fetch, the latency of each mode class, and the ignoring of a second request during a fetch.

// File: rtl/opaddr_pkg.sv
package opaddr_pkg;
   localparam logic [3:0] AM_ZP    = 4'd0;
   localparam logic [3:0] AM_ZPX   = 4'd1;
   localparam logic [3:0] AM_ZPY   = 4'd2;
   localparam logic [3:0] AM_ZIND  = 4'd3;
   localparam logic [3:0] AM_ZXIND = 4'd4;
   localparam logic [3:0] AM_ZINDY = 4'd5;
   localparam logic [3:0] AM_ABS   = 4'd6;
   localparam logic [3:0] AM_ABSX  = 4'd7;
   localparam logic [3:0] AM_ABSY  = 4'd8;
   localparam logic [3:0] AM_ZREL  = 4'd9;
   localparam logic [3:0] AM_AIND  = 4'd10;
   localparam logic [3:0] AM_AXIND = 4'd11;
   localparam logic [3:0] AM_REL   = 4'd12;

   typedef enum logic [1:0] {SQ_IDLE, SQ_LO, SQ_HI, SQ_FIN} seq_state_e;

   function automatic logic needs_pointer(input logic [3:0] m);
      return (m == AM_ZIND) || (m == AM_ZXIND) || (m == AM_ZINDY);
   endfunction
endpackage

// File: rtl/opaddr_direct.sv
module opaddr_direct
   import opaddr_pkg::*;
#(
   parameter int DW       = 8,
   parameter bit ZPY_WRAP = 1'b1
) (
   input  logic [3:0]      mode,
   input  logic [DW-1:0]   op1,
   input  logic [DW-1:0]   op2,
   input  logic [DW-1:0]   idx_x,
   input  logic [DW-1:0]   idx_y,
   output logic [2*DW-1:0] addr,
   output logic            valid
);
   localparam int AW = 2 * DW;

   logic [DW-1:0] zx_lo;
   logic [AW-1:0] zy_addr;
   logic [AW-1:0] abs_base;

   assign zx_lo    = op1 + idx_x;
   assign abs_base = {op2, op1};

   generate
      if (ZPY_WRAP) begin : g_zpy_wrap
         logic [DW-1:0] zy_lo;
         assign zy_lo   = op1 + idx_y;
         assign zy_addr = {{DW{1'b0}}, zy_lo};
      end else begin : g_zpy_carry
         assign zy_addr = {{DW{1'b0}}, op1} + {{DW{1'b0}}, idx_y};
      end
   endgenerate

   always_comb begin
      valid = 1'b1;
      addr  = '0;
      case (mode)
         AM_ZP, AM_ZREL: addr = {{DW{1'b0}}, op1};
         AM_ZPX:         addr = {{DW{1'b0}}, zx_lo};
         AM_ZPY:         addr = zy_addr;
         AM_ABS:         addr = abs_base;
         AM_ABSX:        addr = abs_base + {{DW{1'b0}}, idx_x};
         AM_ABSY:        addr = abs_base + {{DW{1'b0}}, idx_y};
         default:        valid = 1'b0;
      endcase
   end
endmodule

// File: rtl/opaddr_ptr_seq.sv
module opaddr_ptr_seq
   import opaddr_pkg::*;
#(
   parameter int DW        = 8,
   parameter bit PAGE_WRAP = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            launch,
   input  logic [DW-1:0]   base,
   input  logic            wrap_req,
   input  logic [DW-1:0]   y_add,
   output logic            rd_en,
   output logic [2*DW-1:0] rd_addr,
   input  logic [DW-1:0]   rd_data,
   output logic            busy,
   output logic            fin,
   output logic [2*DW-1:0] ptr_ea
);
   localparam int AW = 2 * DW;

   seq_state_e    st;
   logic [DW-1:0] ptr_q;
   logic [DW-1:0] lo_q;
   logic [DW-1:0] yadd_q;
   logic          wrap_q;
   logic [DW-1:0] ptr_nx;
   logic [AW-1:0] hi_addr;

   assign ptr_nx  = ptr_q + 1'b1;
   assign hi_addr = (wrap_q || PAGE_WRAP) ? {{DW{1'b0}}, ptr_nx}
                                          : {{DW{1'b0}}, ptr_q} + AW'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= SQ_IDLE;
         ptr_q  <= '0;
         lo_q   <= '0;
         yadd_q <= '0;
         wrap_q <= 1'b0;
      end else begin
         case (st)
            SQ_IDLE: if (launch) begin
               ptr_q  <= base;
               yadd_q <= y_add;
               wrap_q <= wrap_req;
               st     <= SQ_LO;
            end
            SQ_LO:   st <= SQ_HI;
            SQ_HI: begin
               lo_q <= rd_data;
               st   <= SQ_FIN;
            end
            default: st <= SQ_IDLE;
         endcase
      end
   end

   assign rd_en   = (st == SQ_LO) || (st == SQ_HI);
   assign rd_addr = (st == SQ_HI) ? hi_addr : {{DW{1'b0}}, ptr_q};
   assign busy    = (st != SQ_IDLE);
   assign fin     = (st == SQ_FIN);
   assign ptr_ea  = {rd_data, lo_q} + {{DW{1'b0}}, yadd_q};

   // R9: a pointer fetch is always a pair of reads on consecutive cycles
   a_r9_read_pair: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_en) |=> rd_en ##1 !rd_en);
   // R4 R5: the fetch begins in page zero
   a_r4_first_in_page_zero: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_en) |-> rd_addr[AW-1:DW] == '0);
   // R5: second read steps the low address byte by one
   a_r5_next_byte: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && $past(rd_en)) |-> rd_addr[DW-1:0] == DW'($past(rd_addr[DW-1:0]) + 1'b1));
endmodule

// File: rtl/opaddr_gen.sv
module opaddr_gen
   import opaddr_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int ADDR_W    = 16,
   parameter bit ZPY_WRAP  = 1'b1,
   parameter bit PAGE_WRAP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [3:0]        mode,
   input  logic [DATA_W-1:0] op1,
   input  logic [DATA_W-1:0] op2,
   input  logic [DATA_W-1:0] idx_x,
   input  logic [DATA_W-1:0] idx_y,
   output logic              rd_en,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic [DATA_W-1:0] rd_data,
   output logic [ADDR_W-1:0] ea,
   output logic              done,
   output logic              err
);
   generate
      if (ADDR_W != 2 * DATA_W) begin : g_bad_width
         $error("ADDR_W must be twice DATA_W");
      end
      if (DATA_W < 2) begin : g_bad_data
         $error("DATA_W must be at least 2");
      end
   endgenerate

   logic [ADDR_W-1:0] dir_addr;
   logic              dir_valid;
   logic              busy;
   logic              fin;
   logic [ADDR_W-1:0] ptr_ea;
   logic              accept;
   logic              ptr_mode;
   logic [DATA_W-1:0] ptr_base;
   logic [DATA_W-1:0] y_sel;

   assign ptr_mode = needs_pointer(mode);
   assign accept   = start && !busy;
   assign ptr_base = (mode == AM_ZXIND) ? DATA_W'(op1 + idx_x) : op1;
   assign y_sel    = (mode == AM_ZINDY) ? idx_y : '0;

   opaddr_direct #(.DW(DATA_W), .ZPY_WRAP(ZPY_WRAP)) u_direct (
      .mode(mode), .op1(op1), .op2(op2), .idx_x(idx_x), .idx_y(idx_y),
      .addr(dir_addr), .valid(dir_valid)
   );

   opaddr_ptr_seq #(.DW(DATA_W), .PAGE_WRAP(PAGE_WRAP)) u_seq (
      .clk(clk), .rst_n(rst_n), .launch(accept && ptr_mode), .base(ptr_base),
      .wrap_req(mode == AM_ZXIND), .y_add(y_sel), .rd_en(rd_en),
      .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .fin(fin),
      .ptr_ea(ptr_ea)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ea   <= '0;
         done <= 1'b0;
         err  <= 1'b0;
      end else begin
         done <= 1'b0;
         if (fin) begin
            ea   <= ptr_ea;
            err  <= 1'b0;
            done <= 1'b1;
         end else if (accept && !ptr_mode) begin
            ea   <= dir_valid ? dir_addr : '0;
            err  <= !dir_valid;
            done <= 1'b1;
         end
      end
   end

   // R10: result holds between completions
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(ea) && $stable(err));
   // R8: an error result carries no address
   a_r8_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> ea == '0);
   // R9: completion never overlaps a pointer read
   a_r9_no_read_at_done: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> !done);
   // R11: a fetch in progress produces no completion until its last read is done
   a_r11_busy_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> !done);
endmodule

// File: tb/opaddr_gen_test.sv
`timescale 1ns/1ps
module opaddr_gen_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [3:0]  mode = '0;
   logic [7:0]  op1 = '0, op2 = '0, idx_x = '0, idx_y = '0;
   logic        rd_en;
   logic [15:0] rd_addr;
   logic [7:0]  rd_data = '0;
   logic [15:0] ea;
   logic        done, err;

   int n_chk = 0;
   int n_bad = 0;
   int rd_total = 0;
   logic [15:0] rd_prev = '0, rd_last = '0;

   always #2 clk = ~clk;

   opaddr_gen uut (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .op1(op1),
      .op2(op2), .idx_x(idx_x), .idx_y(idx_y), .rd_en(rd_en),
      .rd_addr(rd_addr), .rd_data(rd_data), .ea(ea), .done(done), .err(err)
   );

   function automatic logic [7:0] mb(input logic [15:0] a);
      return ((a[7:0] * 8'd7) + 8'h3C) ^ a[15:8];
   endfunction

   always @(posedge clk) begin
      if (rd_en) begin
         rd_data  <= mb(rd_addr);
         rd_prev  <= rd_last;
         rd_last  <= rd_addr;
         rd_total <= rd_total + 1;
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   // issue one request and check address, error, latency and reads
   task automatic run(input logic [3:0] m, input logic [7:0] a, input logic [7:0] b,
                      input logic [7:0] x, input logic [7:0] y,
                      input logic [15:0] exp_ea, input bit exp_err,
                      input int exp_lat, input logic [15:0] exp_r0,
                      input logic [15:0] exp_r1, input string tag);
      int lat = 0;
      int rd0;
      @(negedge clk);
      rd0 = rd_total;
      mode = m; op1 = a; op2 = b; idx_x = x; idx_y = y; start = 1'b1;
      while (1) begin
         @(negedge clk);
         start = 1'b0;
         lat++;
         if (done || lat > 20) break;
      end
      chk(done, {tag, " done"}, 32'(done), 1);
      chk(lat == exp_lat, {tag, " latency"}, lat, exp_lat);
      chk(ea == exp_ea, {tag, " ea"}, ea, exp_ea);
      chk(err == exp_err, {tag, " err"}, err, exp_err);
      chk((rd_total - rd0) == (exp_lat == 4 ? 2 : 0), {tag, " reads"},
          rd_total - rd0, exp_lat == 4 ? 2 : 0);
      if (exp_lat == 4) begin
         chk(rd_prev == exp_r0, {tag, " first read"}, rd_prev, exp_r0);
         chk(rd_last == exp_r1, {tag, " second read"}, rd_last, exp_r1);
      end
   endtask

   task automatic t_reset();
      #1;
      chk(!done && !err && !rd_en && ea == 0, "R12 reset outputs",
          {done, err, rd_en, ea}, 0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!done && !err && !rd_en && ea == 0, "R12 after reset",
          {done, err, rd_en, ea}, 0);
   endtask

   task automatic t_direct();
      run(4'd0, 8'h42, 8'h99, 8'h11, 8'h22, 16'h0042, 0, 1, 0, 0, "R1 page zero");
      run(4'd9, 8'h80, 8'h12, 8'h00, 8'h00, 16'h0080, 0, 1, 0, 0, "R1 zp relative");
      run(4'd1, 8'hF0, 8'h77, 8'h20, 8'h00, 16'h0010, 0, 1, 0, 0, "R2 zp,X wrap");
      run(4'd1, 8'h10, 8'h77, 8'h05, 8'h00, 16'h0015, 0, 1, 0, 0, "R2 zp,X");
      run(4'd2, 8'hFF, 8'h77, 8'h00, 8'h02, 16'h0001, 0, 1, 0, 0, "R3 zp,Y wrap");
      run(4'd6, 8'h34, 8'h12, 8'h01, 8'h01, 16'h1234, 0, 1, 0, 0, "R7 absolute");
      run(4'd7, 8'hF0, 8'hFF, 8'h20, 8'h00, 16'h0010, 0, 1, 0, 0, "R7 abs,X wrap");
      run(4'd8, 8'hF0, 8'h12, 8'h00, 8'h20, 16'h1310, 0, 1, 0, 0, "R7 abs,Y carry");
   endtask

   task automatic t_pointer();
      run(4'd3, 8'h30, 8'h00, 8'h44, 8'h55, {mb(16'h0031), mb(16'h0030)}, 0, 4,
          16'h0030, 16'h0031, "R4 zp indirect");
      run(4'd3, 8'hFF, 8'h00, 8'h00, 8'h00, {mb(16'h0000), mb(16'h00FF)}, 0, 4,
          16'h00FF, 16'h0000, "R4 R9 indirect wrap");
      run(4'd4, 8'hFE, 8'h00, 8'h01, 8'h33, {mb(16'h0000), mb(16'h00FF)}, 0, 4,
          16'h00FF, 16'h0000, "R5 X indirect wrap");
      run(4'd4, 8'h20, 8'h00, 8'h08, 8'h00, {mb(16'h0029), mb(16'h0028)}, 0, 4,
          16'h0028, 16'h0029, "R5 X indirect");
      run(4'd5, 8'h50, 8'h00, 8'h99, 8'hC0,
          {mb(16'h0051), mb(16'h0050)} + 16'h00C0, 0, 4,
          16'h0050, 16'h0051, "R6 indirect Y");
   endtask

   task automatic t_errors();
      for (int m = 10; m < 16; m++) begin
         if (m != 14)
            run(4'(m), 8'h12, 8'h34, 8'h01, 8'h01, 16'h0000, 1, 1, 0, 0,
                $sformatf("R8 mode %0d", m));
      end
      run(4'd0, 8'h07, 8'h00, 8'h00, 8'h00, 16'h0007, 0, 1, 0, 0, "R10 err clears");
   endtask

   task automatic t_hold();
      logic [15:0] e0;
      run(4'd6, 8'hCD, 8'hAB, 8'h00, 8'h00, 16'hABCD, 0, 1, 0, 0, "R10 setup");
      e0 = ea;
      @(negedge clk);
      chk(!done, "R10 single pulse", 32'(done), 0);
      mode = 4'd1; op1 = 8'h01;
      repeat (3) @(negedge clk);
      chk(ea == e0 && !err, "R10 hold", ea, e0);
   endtask

   task automatic t_busy();
      int lat = 0;
      int seen = 0;
      logic [15:0] exp;
      exp = {mb(16'h0061), mb(16'h0060)};
      @(negedge clk);
      mode = 4'd3; op1 = 8'h60; start = 1'b1;
      for (int k = 1; k <= 8; k++) begin
         @(negedge clk);
         start = (k == 1) || (k == 2);
         if (start) begin mode = 4'd0; op1 = 8'hEE; end
         if (k >= 3) start = 1'b0;
         if (done) begin seen++; if (lat == 0) lat = k; end
         if (k == 4) chk(ea == exp, "R11 result kept", ea, exp);
      end
      chk(seen == 1, "R11 one completion", seen, 1);
      chk(lat == 4, "R11 latency", lat, 4);
      chk(ea == exp, "R11 ea unchanged", ea, exp);
   endtask

   initial begin
      t_reset();
      t_direct();
      t_pointer();
      t_errors();
      t_hold();
      t_busy();
      summary();
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
   end
endmodule